// File: doc/BRIEF.md
# Vector Rounding Right-Shift Unit

This block executes the two fixed-point scaling shifts of a vector unit: a logical right shift and an arithmetic right shift, each followed by rounding. For every element, the source-two element is shifted right by an amount taken from the matching source-one element. An increment is then added. The increment comes from the bits the shift discards and from the selected rounding mode. The arithmetic form shifts the element after sign extension to twice its width, so the bits shifted in are copies of the sign.

A caller presents the encoded instruction word, the element width, the rounding mode, both source vectors, the old destination vector and the mask bits, and raises `start` for one cycle. The unit latches everything and processes one element per cycle. It merges each result into a copy of the old destination. When the last element has been written, it pulses `done`. The element-start index it exposes returns to zero when the operation completes.

Top module: `vfx_scale_shift`

## Requirements
- R1: On an accepted start the unit latches instruction fields from the word: bit 26 selects arithmetic (1) or logical (0), bit 25 is the unmasked flag, bits 24:20 the second source, bits 19:15 the first source, bits 11:7 the destination. The three register numbers appear on `vs2_idx`, `vs1_idx` and `vd_idx`.
- R2: `sew_sel` encodes the element width as 0→8, 1→16, 2→32, 3→64 bits. Element i occupies bits [i*SEW +: SEW] of each vector. The shift amount is the low log2(SEW) bits of the source-one element, and higher bits are ignored.
- R3: The logical form produces (v >> d) plus the increment, truncated to SEW bits, with zeros shifted in.
- R4: The arithmetic form sign-extends v to 2*SEW bits, shifts right by d, keeps the low SEW bits and adds the increment, truncated to SEW bits.
- R5: The increment is computed from the unshifted v and d, with `rnd_mode` encoded as follows. 0 adds bit d-1. 1 adds bit d-1 only when some lower discarded bit is set or bit d is set. 2 adds nothing. 3 adds 1 when bit d is clear and any discarded bit is set.
- R6: A shift amount of zero returns the element unchanged in every mode and both forms.
- R7: When the unmasked flag is 0, an element whose `mask_bits[i]` is 0 keeps the old destination value. When the flag is 1, every element is written.
- R8: `done` is a one-cycle pulse. If `start` is accepted at edge k, `done` is high after edge k+VLEN/SEW. `busy` is high in between, and a `start` while busy is ignored.
- R9: `vstart` shows the index of the element being processed while busy and is zero when idle and when `done` is high.
- R10: After reset, `busy`, `done`, `result`, `vstart` and the register-number outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| insn | input | 32 | Encoded instruction word |
| sew_sel | input | 2 | Element width code |
| rnd_mode | input | 2 | Rounding mode code |
| src1 | input | VLEN | Shift-amount vector |
| src2 | input | VLEN | Data vector |
| old_dst | input | VLEN | Previous destination contents |
| mask_bits | input | VLEN/8 | Per-element enable, bit i for element i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vstart | output | log2(VLEN/8) | Current element index, zero when idle |
| result | output | VLEN | Merged destination vector |
| vd_idx | output | 5 | Latched destination register number |
| vs1_idx | output | 5 | Latched first source register number |
| vs2_idx | output | 5 | Latched second source register number |

## Verification
The bench sweeps every element width, every rounding mode and both shift forms over four input families. Random elements and random amounts exercise general rounding. All-zero amounts separate a correct zero-shift path from an increment leaking in at d=0. Elements built with exactly the half-way pattern below d tell the four rounding modes apart at the tie, including the even/odd decision on bit d. Amounts with random bits above log2(SEW), under partial masks, show that the amount is reduced and that inactive lanes keep the old destination. A second start issued mid-operation shows that the latched fields and data are not disturbed.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

  localparam int LANE_W = 64;

  typedef enum logic [1:0] {
    RND_NEAR_UP   = 2'd0,
    RND_NEAR_EVEN = 2'd1,
    RND_DOWN      = 2'd2,
    RND_ODD       = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    logic       arith;
    logic       unmasked;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic [4:0] rd;
  } op_fields_t;

  function automatic logic [6:0] sew_width(input logic [1:0] code);
    return 7'd8 << code;
  endfunction

  function automatic logic [LANE_W-1:0] width_mask(input logic [1:0] code);
    logic [LANE_W-1:0] m;
    if (code == 2'd3) m = '1;
    else              m = (64'd1 << sew_width(code)) - 64'd1;
    return m;
  endfunction

endpackage

// File: rtl/vfx_lane_pick.sv
module vfx_lane_pick #(
  parameter int VLEN = 128,
  parameter int IDXW = 4
) (
  input  logic [VLEN-1:0] vec,
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      sew_sel,
  output logic [63:0]     lane
);
  localparam int OFFW = $clog2(VLEN);

  logic [OFFW-1:0] off;
  logic [VLEN-1:0] shifted;
  logic [VLEN-1:0] unused_upper;

  always_comb begin
    off          = OFFW'({{(OFFW){1'b0}}, idx} << (3 + sew_sel));
    shifted      = vec >> off;
    lane         = shifted[63:0];
    unused_upper = shifted;
  end
endmodule

// File: rtl/vfx_elem_round.sv
module vfx_elem_round
  import vfx_pkg::*;
(
  input  logic [63:0] elem_in,
  input  logic [5:0]  amt_raw,
  input  logic [1:0]  sew_sel,
  input  rnd_mode_e   mode,
  input  logic        arith,
  output logic [63:0] elem_out
);
  logic [63:0]  wmask;
  logic [5:0]   amt;
  logic [5:0]   top_bit;
  logic [63:0]  v;
  logic         neg;
  logic [127:0] ext;
  logic [127:0] sh;
  logic         rbit;
  logic         lsb;
  logic         below;
  logic         any_lost;
  logic         inc;
  logic [63:0]  unused_sh_hi;

  always_comb begin
    wmask   = width_mask(sew_sel);
    top_bit = 6'(sew_width(sew_sel) - 7'd1);
    amt     = amt_raw & top_bit;
    v       = elem_in & wmask;
    neg     = arith & v[top_bit];
    ext     = {neg ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0, v | (neg ? ~wmask : 64'd0)};
    sh      = ext >> amt;
    unused_sh_hi = sh[127:64];

    lsb      = v[amt];
    rbit     = v[amt - 6'd1];
    below    = |(v & ((64'd1 << (amt - 6'd1)) - 64'd1));
    any_lost = |(v & ((64'd1 << amt) - 64'd1));

    if (amt == 6'd0) begin
      inc = 1'b0;
    end else begin
      unique case (mode)
        RND_NEAR_UP:   inc = rbit;
        RND_NEAR_EVEN: inc = rbit & (below | lsb);
        RND_DOWN:      inc = 1'b0;
        RND_ODD:       inc = ~lsb & any_lost;
        default:       inc = 1'b0;
      endcase
    end

    elem_out = (sh[63:0] + {63'd0, inc}) & wmask;
  end
endmodule

// File: rtl/vfx_step_ctrl.sv
module vfx_step_ctrl #(
  parameter int NMAX = 16,
  parameter int IDXW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      sew_cur,
  output logic            load,
  output logic            step,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] idx
);
  logic [IDXW-1:0] last;

  always_comb begin
    load = start & ~busy;
    step = busy;
    last = IDXW'((NMAX >> sew_cur) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == last) begin
          busy <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vfx_scale_shift.sv
module vfx_scale_shift
  import vfx_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int NMAX = VLEN / 8,
  localparam int IDXW = $clog2(NMAX)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [31:0]     insn,
  input  logic [1:0]      sew_sel,
  input  logic [1:0]      rnd_mode,
  input  logic [VLEN-1:0] src1,
  input  logic [VLEN-1:0] src2,
  input  logic [VLEN-1:0] old_dst,
  input  logic [NMAX-1:0] mask_bits,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] vstart,
  output logic [VLEN-1:0] result,
  output logic [4:0]      vd_idx,
  output logic [4:0]      vs1_idx,
  output logic [4:0]      vs2_idx
);
  localparam int OFFW = $clog2(VLEN);

  op_fields_t      dec, op_q;
  logic [VLEN-1:0] s1_q, s2_q;
  logic [NMAX-1:0] mask_q;
  logic [1:0]      sew_q;
  rnd_mode_e       mode_q;
  logic            load, step;
  logic [IDXW-1:0] idx;
  logic [63:0]     lane1, lane2, lane_res;
  logic            active;
  logic [OFFW-1:0] off;
  logic [VLEN-1:0] ins_mask, ins_val;
  logic [31:0]     unused_insn;
  logic [57:0]     unused_amt_hi;

  always_comb begin
    dec.arith    = insn[26];
    dec.unmasked = insn[25];
    dec.rs2      = insn[24:20];
    dec.rs1      = insn[19:15];
    dec.rd       = insn[11:7];
    unused_insn  = insn;
  end

  vfx_step_ctrl #(.NMAX(NMAX), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .sew_cur(sew_q),
    .load(load), .step(step), .busy(busy), .done(done), .idx(idx)
  );

  vfx_lane_pick #(.VLEN(VLEN), .IDXW(IDXW)) u_pick1 (
    .vec(s1_q), .idx(idx), .sew_sel(sew_q), .lane(lane1)
  );

  vfx_lane_pick #(.VLEN(VLEN), .IDXW(IDXW)) u_pick2 (
    .vec(s2_q), .idx(idx), .sew_sel(sew_q), .lane(lane2)
  );

  vfx_elem_round u_round (
    .elem_in(lane2), .amt_raw(lane1[5:0]), .sew_sel(sew_q),
    .mode(mode_q), .arith(op_q.arith), .elem_out(lane_res)
  );

  always_comb begin
    unused_amt_hi = lane1[63:6];
    active   = op_q.unmasked | mask_q[idx];
    off      = OFFW'({{(OFFW){1'b0}}, idx} << (3 + sew_q));
    ins_mask = VLEN'(width_mask(sew_q)) << off;
    ins_val  = VLEN'(lane_res) << off;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      mask_q <= '0;
      sew_q  <= 2'd0;
      mode_q <= RND_NEAR_UP;
      result <= '0;
    end else if (load) begin
      op_q   <= dec;
      s1_q   <= src1;
      s2_q   <= src2;
      mask_q <= mask_bits;
      sew_q  <= sew_sel;
      mode_q <= rnd_mode_e'(rnd_mode);
      result <= old_dst;
    end else if (step && active) begin
      result <= (result & ~ins_mask) | (ins_val & ins_mask);
    end
  end

  assign vstart  = idx;
  assign vd_idx  = op_q.rd;
  assign vs1_idx = op_q.rs1;
  assign vs2_idx = op_q.rs2;
endmodule

// File: rtl/vfx_scale_shift_chk.sv
module vfx_scale_shift_chk #(
  parameter int VLEN = 128,
  localparam int IDXW = $clog2(VLEN / 8)
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [IDXW-1:0] vstart,
  input logic [VLEN-1:0] result,
  input logic [4:0]      vd_idx
);
  // R8
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R8
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(vd_idx));

  // R9
  vstart_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> vstart == '0);

  // R7
  result_hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));
endmodule

bind vfx_scale_shift vfx_scale_shift_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .vstart(vstart), .result(result), .vd_idx(vd_idx)
);

// File: tb/sim_vfx_scale_shift.sv
module sim_vfx_scale_shift;
  localparam int VLEN = 128;
  localparam int NE   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [31:0]     insn = '0;
  logic [1:0]      sew_sel = '0;
  logic [1:0]      rnd_mode = '0;
  logic [VLEN-1:0] src1 = '0, src2 = '0, old_dst = '0;
  logic [NE-1:0]   mask_bits = '0;
  logic            busy, done;
  logic [3:0]      vstart;
  logic [VLEN-1:0] result;
  logic [4:0]      vd_idx, vs1_idx, vs2_idx;

  int checks = 0;
  int fails = 0;
  logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;
  logic [63:0] e1 [NE];
  logic [63:0] e2 [NE];
  logic [63:0] eo [NE];

  always #2.5 clk = ~clk;

  vfx_scale_shift #(.VLEN(VLEN)) u0 (
    .clk(clk), .rst(rst), .start(start), .insn(insn), .sew_sel(sew_sel),
    .rnd_mode(rnd_mode), .src1(src1), .src2(src2), .old_dst(old_dst),
    .mask_bits(mask_bits), .busy(busy), .done(done), .vstart(vstart),
    .result(result), .vd_idx(vd_idx), .vs1_idx(vs1_idx), .vs2_idx(vs2_idx)
  );

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish (got hang, expected completion)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [63:0] rnd64();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  function automatic logic [63:0] wm(int sw);
    return (sw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << sw) - 64'd1);
  endfunction

  // Independent model: floor division by 2^d, remainder compared with half.
  function automatic logic [63:0] model(logic [63:0] vin, logic [63:0] ain,
                                        int sw, int md, bit ar);
    logic [63:0] v;
    logic signed [131:0] val, q, r, half;
    int d;
    bit inc;
    v   = vin & wm(sw);
    d   = int'(ain % 64'(sw));
    val = $signed({68'd0, v});
    if (ar && v[sw-1]) val = val - (132'sd1 <<< sw);
    q    = val >>> d;
    r    = val - (q <<< d);
    half = (d > 0) ? (132'sd1 <<< (d - 1)) : 132'sd0;
    inc  = 1'b0;
    if (d > 0) begin
      case (md)
        0: inc = (r >= half);
        1: inc = (r > half) || (r == half && q[0]);
        2: inc = 1'b0;
        default: inc = (r != 0) && !q[0];
      endcase
    end
    return 64'(q + 132'(inc)) & wm(sw);
  endfunction

  function automatic logic [VLEN-1:0] pack(ref logic [63:0] e [NE], int sw);
    logic [VLEN-1:0] b = '0;
    for (int i = 0; i < VLEN / sw; i++)
      b = b | (VLEN'(e[i] & wm(sw)) << (i * sw));
    return b;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(int sc, int md, bit ar, bit vm, logic [4:0] rd,
                        logic [4:0] r1, logic [4:0] r2, bit poke);
    int sw, n, cnt;
    bit vs_ok;
    logic [63:0] got, exp;
    sw = 8 << sc;
    n  = VLEN / sw;
    @(negedge clk);
    insn      = {5'b10101, ar, vm, r2, r1, 3'b000, rd, 7'b1010111};
    sew_sel   = 2'(sc);
    rnd_mode  = 2'(md);
    src1      = pack(e1, sw);
    src2      = pack(e2, sw);
    old_dst   = pack(eo, sw);
    start     = 1'b1;
    cnt   = 0;
    vs_ok = 1'b1;
    do begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (poke && cnt == 2) begin
        start = 1'b1;
        insn  = {5'b10101, ~ar, ~vm, ~r2, ~r1, 3'b000, ~rd, 7'b1010111};
        src2  = ~src2;
      end else begin
        start = 1'b0;
      end
      if (busy && vstart != 4'(cnt - 1)) vs_ok = 1'b0;
    end while (!done && cnt < 100);
    // R8: done after VLEN/SEW element cycles plus the load cycle
    check(cnt == n + 1 && !busy, "R8 latency", 128'(cnt), 128'(n + 1));
    // R9
    check(vs_ok && vstart == 4'd0, "R9 vstart", 128'(vstart), 128'd0);
    // R1
    check(vd_idx == rd && vs1_idx == r1 && vs2_idx == r2, "R1 fields",
          {vd_idx, vs1_idx, vs2_idx}, {rd, r1, r2});
    for (int i = 0; i < n; i++) begin
      got = 64'(result >> (i * sw)) & wm(sw);
      if (vm || mask_bits[i]) exp = model(e2[i], e1[i], sw, md, ar);
      else                    exp = eo[i] & wm(sw);
      // R2 R3 R4 R5 R6 R7
      check(got == exp, (vm || mask_bits[i]) ?
            (ar ? "R4/R5 arith element" : "R3/R5 logical element") :
            "R7 masked element", 128'(got), 128'(exp));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    check(!busy && !done && result == '0 && vstart == 0 &&
          vd_idx == 0 && vs1_idx == 0 && vs2_idx == 0,
          "R10 reset", {busy, done, result[63:0]}, 128'd0);

    for (int sc = 0; sc < 4; sc++) begin
      for (int md = 0; md < 4; md++) begin
        for (int ar = 0; ar < 2; ar++) begin
          for (int p = 0; p < 4; p++) begin
            int sw;
            sw = 8 << sc;
            for (int i = 0; i < NE; i++) begin
              int d;
              eo[i] = rnd64();
              e2[i] = rnd64();
              e1[i] = rnd64();
              d = (i % (sw - 1)) + 1;
              case (p)
                0: e1[i] = e1[i] % 64'(sw);
                1: e1[i] = 64'(sw) * (e1[i] & 64'hFF);     // R6 amount zero
                2: begin                                 // R5 exact ties
                  e2[i] = (e2[i] & ~((64'd1 << d) - 64'd1)) | (64'd1 << (d - 1));
                  e1[i] = 64'(d) + 64'(sw) * (e1[i] & 64'hF);
                end
                default: ;                               // R2 high amount bits
              endcase
            end
            mask_bits = NE'(rnd64());
            run_op(sc, md, ar[0], (p % 2) == 0, 5'(rnd64()), 5'(rnd64()),
                   5'(rnd64()), 1'b0);
          end
        end
      end
    end

    // R8: second start mid-operation is ignored
    for (int i = 0; i < NE; i++) begin
      e1[i] = rnd64(); e2[i] = rnd64(); eo[i] = rnd64();
    end
    mask_bits = '1;
    run_op(1, 1, 1'b1, 1'b1, 5'd9, 5'd3, 5'd17, 1'b1);
    run_op(3, 0, 1'b0, 1'b0, 5'd1, 5'd2, 5'd4, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule